// File: doc/BRIEF.md
# Privilege-Gated Security Register Bank

This block is the register bank of a small security core. It follows whether the processor is still running trusted boot firmware or has handed over to an untrusted application, and it uses that state to decide who may see the device identifier and who may change the compound identity words and the RAM scrambling values. It sits on a simple 32-bit register bus with a chip select, a write enable, a word address and write data. Read data comes back one clock later.

The block starts in firmware mode. It moves to application mode on the first valid instruction fetch from the start address of application RAM, and only a reset brings it back. A syscall input grants firmware privilege again while it is high. Privilege is firmware mode OR syscall, and it is evaluated on every bus access. Without privilege, identifier reads return zero, and writes to the identity words and to the scramble registers are dropped.

The word map is as follows. The identifier words are at 0x20 and 0x21. The eight identity words are at 0x40 to 0x47. The address-scramble register is at 0x60 and the data-scramble register is at 0x61. Every other word address is unmapped.

Top module: `secbank_top`

## Requirements
- R1: After reset, `appMode` is 0, `busRdata` is 0, both scramble outputs are 0 and all eight identity words are 0.
- R2: A fetch with `fetchValid`=1 and `fetchAddr` equal to the application start address (default 0x40000000) sets `appMode` to 1 from the next cycle. A fetch to any other address, or with `fetchValid`=0, leaves the mode unchanged.
- R3: Once set, `appMode` stays 1 whatever `syscall` does, until the next reset.
- R4: With privilege, reads of word 0x20 return 0x00010203 and reads of word 0x21 return 0x04050607. Without privilege, both reads return 0 and `udiView` is 0. With privilege, `udiView` is {word 0x21, word 0x20}.
- R5: With privilege, a write to word 0x40+i (i = 0..7) stores the data, and a read of the same word returns it.
- R6: Without privilege, writes to the identity words are dropped, and reads still return the previously stored values.
- R7: A privileged write to word 0x60 stores only the low 15 bits of the data on `ramAddrScramble` (0xdeadbeef gives 0x3eef). A privileged write to word 0x61 stores all 32 bits on `ramDataScramble`.
- R8: Bus reads of words 0x60 and 0x61 always return 0.
- R9: Without privilege, writes to words 0x60 and 0x61 leave both scramble outputs unchanged.
- R10: `busRdata` is updated in the cycle after a read strobe (`busCs`=1, `busWe`=0) and holds its value otherwise. Reads of unmapped words return 0.
- R11: Writes to the identifier words have no effect on what they read back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busCs | input | 1 | Bus access strobe |
| busWe | input | 1 | 1 = write, 0 = read |
| busAddr | input | 8 | Word address |
| busWdata | input | 32 | Write data |
| fetchAddr | input | 32 | CPU instruction fetch address |
| fetchValid | input | 1 | Fetch address is valid |
| syscall | input | 1 | Temporary privilege restore |
| busRdata | output | 32 | Registered read data |
| appMode | output | 1 | 1 = application mode |
| udiView | output | 64 | Gated identifier, high word = word 0x21 |
| cdiFlat | output | 256 | Identity words, word i at bits 32*i+31:32*i |
| ramAddrScramble | output | 15 | Address scramble value |
| ramDataScramble | output | 32 | Data scramble value |

## Verification
The same accesses are run in three privilege contexts: firmware mode, application mode without syscall, and application mode with syscall. Comparing them shows whether gating depends on the mode register alone or on the OR with syscall. The identity words and scramble values are given distinct data patterns before and after the mode change. A dropped write therefore shows as the old value remaining, and a leaked write shows as the new value appearing. Directed cases cover the following:
- fetches that must not change the mode: the wrong address, or a low valid strobe;
- syscall toggling after the mode change;
- read latency;
- a reset out of application mode.

// File: rtl/secbank_pkg.sv
package secbank_pkg;

  localparam int IDX_W = 8;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_UDI  = 2'd1,
    SEL_CDI  = 2'd2,
    SEL_SCR  = 2'd3
  } rd_sel_e;

  typedef struct packed {
    logic             wrCdi;
    logic             wrAddrScr;
    logic             wrDataScr;
    logic             rdEn;
    rd_sel_e          rdSel;
    logic [IDX_W-1:0] idx;
    logic             udiOpen;
  } bank_stb_t;

endpackage

// File: rtl/secbank_ctrl.sv
module secbank_ctrl
  import secbank_pkg::*;
#(
  parameter int          ADDR_W    = 8,
  parameter int          CDI_WORDS = 8,
  parameter int          UDI_BASE  = 'h20,
  parameter int          CDI_BASE  = 'h40,
  parameter int          SCR_BASE  = 'h60,
  parameter logic [31:0] APP_START = 32'h4000_0000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busCs,
  input  logic              busWe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [31:0]       fetchAddr,
  input  logic              fetchValid,
  input  logic              syscall,
  output logic              appMode,
  output bank_stb_t         stb
);

  localparam logic [ADDR_W-1:0] UDI_A0 = ADDR_W'(UDI_BASE);
  localparam logic [ADDR_W-1:0] UDI_A1 = ADDR_W'(UDI_BASE + 1);
  localparam logic [ADDR_W-1:0] CDI_A  = ADDR_W'(CDI_BASE);
  localparam logic [ADDR_W-1:0] SCR_A0 = ADDR_W'(SCR_BASE);
  localparam logic [ADDR_W-1:0] SCR_A1 = ADDR_W'(SCR_BASE + 1);
  localparam logic [ADDR_W-1:0] CDI_N  = ADDR_W'(CDI_WORDS);

  logic              appModeReg;
  logic              privileged;
  logic              fetchHit;
  logic [ADDR_W-1:0] cdiOff;
  logic              hitUdi;
  logic              hitCdi;
  logic              hitAddrScr;
  logic              hitDataScr;
  logic              wrAccess;
  logic              rdAccess;

  assign fetchHit = fetchValid && (fetchAddr == APP_START);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      appModeReg <= 1'b0;
    end else if (fetchHit) begin
      appModeReg <= 1'b1;
    end
  end

  assign appMode    = appModeReg;
  assign privileged = !appModeReg || syscall;

  assign cdiOff     = busAddr - CDI_A;
  assign hitCdi     = cdiOff < CDI_N;
  assign hitUdi     = (busAddr == UDI_A0) || (busAddr == UDI_A1);
  assign hitAddrScr = busAddr == SCR_A0;
  assign hitDataScr = busAddr == SCR_A1;
  assign wrAccess   = busCs && busWe && privileged;
  assign rdAccess   = busCs && !busWe;

  always_comb begin
    stb           = '0;
    stb.udiOpen   = privileged;
    stb.rdEn      = rdAccess;
    stb.wrCdi     = wrAccess && hitCdi;
    stb.wrAddrScr = wrAccess && hitAddrScr;
    stb.wrDataScr = wrAccess && hitDataScr;
    if (hitCdi) begin
      stb.rdSel = SEL_CDI;
      stb.idx   = IDX_W'(cdiOff);
    end else if (hitUdi) begin
      stb.rdSel = SEL_UDI;
      stb.idx   = IDX_W'(busAddr == UDI_A1);
    end else if (hitAddrScr || hitDataScr) begin
      stb.rdSel = SEL_SCR;
    end else begin
      stb.rdSel = SEL_NONE;
    end
  end

  // R2: a fetch from the application start enters application mode
  p_enter_app_r2: assert property (@(posedge clk) disable iff (!rstN)
    (fetchValid && fetchAddr == APP_START) |=> appMode);

  // R3: application mode is left only through reset
  p_mode_sticky_r3: assert property (@(posedge clk) disable iff (!rstN)
    appMode |=> appMode);

  // R6, R9: no write strobe leaves control while locked
  p_locked_no_write_r6: assert property (@(posedge clk) disable iff (!rstN)
    (appMode && !syscall) |-> !(stb.wrCdi || stb.wrAddrScr || stb.wrDataScr));

endmodule

// File: rtl/secbank_dp.sv
module secbank_dp
  import secbank_pkg::*;
#(
  parameter int          CDI_WORDS  = 8,
  parameter int          SCR_ADDR_W = 15,
  parameter logic [31:0] UDI_WORD0  = 32'h0001_0203,
  parameter logic [31:0] UDI_WORD1  = 32'h0405_0607
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  bank_stb_t                 stb,
  input  logic [31:0]               busWdata,
  output logic [31:0]               busRdata,
  output logic [63:0]               udiView,
  output logic [32*CDI_WORDS-1:0]   cdiFlat,
  output logic [SCR_ADDR_W-1:0]     ramAddrScramble,
  output logic [31:0]               ramDataScramble
);

  localparam int CDI_IDX_W = (CDI_WORDS > 1) ? $clog2(CDI_WORDS) : 1;

  logic [31:0]           cdiWord [CDI_WORDS];
  logic [SCR_ADDR_W-1:0] addrScrReg;
  logic [31:0]           dataScrReg;
  logic [31:0]           rdNext;
  logic [31:0]           udiSel;

  for (genvar i = 0; i < CDI_WORDS; i++) begin : g_cdi
    always_ff @(posedge clk) begin
      if (!rstN) begin
        cdiWord[i] <= '0;
      end else if (stb.wrCdi && stb.idx[CDI_IDX_W-1:0] == CDI_IDX_W'(i)) begin
        cdiWord[i] <= busWdata;
      end
    end
    assign cdiFlat[32*i +: 32] = cdiWord[i];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrScrReg <= '0;
      dataScrReg <= '0;
    end else begin
      if (stb.wrAddrScr) addrScrReg <= busWdata[SCR_ADDR_W-1:0];
      if (stb.wrDataScr) dataScrReg <= busWdata;
    end
  end

  assign ramAddrScramble = addrScrReg;
  assign ramDataScramble = dataScrReg;
  assign udiView         = stb.udiOpen ? {UDI_WORD1, UDI_WORD0} : 64'h0;
  assign udiSel          = stb.idx[0] ? udiView[63:32] : udiView[31:0];

  always_comb begin
    case (stb.rdSel)
      SEL_UDI: rdNext = udiSel;
      SEL_CDI: rdNext = cdiWord[stb.idx[CDI_IDX_W-1:0]];
      default: rdNext = 32'h0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busRdata <= '0;
    end else if (stb.rdEn) begin
      busRdata <= rdNext;
    end
  end

  // R6: identity words only move on a write strobe
  p_cdi_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    !stb.wrCdi |=> $stable(cdiFlat));

  // R9: scramble values only move on their strobes
  p_scr_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    !(stb.wrAddrScr || stb.wrDataScr) |=> ($stable(ramAddrScramble) && $stable(ramDataScramble)));

  // R8: scramble registers read back as zero
  p_scr_read_zero_r8: assert property (@(posedge clk) disable iff (!rstN)
    (stb.rdEn && stb.rdSel == SEL_SCR) |=> busRdata == 32'h0);

  // R10: read data only changes after a read strobe
  p_rd_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    !stb.rdEn |=> $stable(busRdata));

endmodule

// File: rtl/secbank_top.sv
module secbank_top
  import secbank_pkg::*;
#(
  parameter int          ADDR_W     = 8,
  parameter int          CDI_WORDS  = 8,
  parameter int          SCR_ADDR_W = 15,
  parameter int          UDI_BASE   = 'h20,
  parameter int          CDI_BASE   = 'h40,
  parameter int          SCR_BASE   = 'h60,
  parameter logic [31:0] APP_START  = 32'h4000_0000,
  parameter logic [31:0] UDI_WORD0  = 32'h0001_0203,
  parameter logic [31:0] UDI_WORD1  = 32'h0405_0607
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    busCs,
  input  logic                    busWe,
  input  logic [ADDR_W-1:0]       busAddr,
  input  logic [31:0]             busWdata,
  input  logic [31:0]             fetchAddr,
  input  logic                    fetchValid,
  input  logic                    syscall,
  output logic [31:0]             busRdata,
  output logic                    appMode,
  output logic [63:0]             udiView,
  output logic [32*CDI_WORDS-1:0] cdiFlat,
  output logic [SCR_ADDR_W-1:0]   ramAddrScramble,
  output logic [31:0]             ramDataScramble
);

  bank_stb_t stb;

  secbank_ctrl #(
    .ADDR_W(ADDR_W), .CDI_WORDS(CDI_WORDS), .UDI_BASE(UDI_BASE),
    .CDI_BASE(CDI_BASE), .SCR_BASE(SCR_BASE), .APP_START(APP_START)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .busCs(busCs), .busWe(busWe), .busAddr(busAddr),
    .fetchAddr(fetchAddr), .fetchValid(fetchValid), .syscall(syscall),
    .appMode(appMode), .stb(stb)
  );

  secbank_dp #(
    .CDI_WORDS(CDI_WORDS), .SCR_ADDR_W(SCR_ADDR_W),
    .UDI_WORD0(UDI_WORD0), .UDI_WORD1(UDI_WORD1)
  ) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .busWdata(busWdata),
    .busRdata(busRdata), .udiView(udiView), .cdiFlat(cdiFlat),
    .ramAddrScramble(ramAddrScramble), .ramDataScramble(ramDataScramble)
  );

endmodule

// File: tb/tb_secbank_top.sv
module tb_secbank_top;

  localparam int NV = 30;
  localparam logic [31:0] APP_START = 32'h4000_0000;
  localparam logic [1:0] OP_W = 2'd0, OP_R = 2'd1, OP_F = 2'd2, OP_C = 2'd3;

  // {op[74:73], syscall[72], addr[71:64], data[63:32], expect[31:0]}
  localparam logic [74:0] VEC [NV] = '{
    {OP_W, 1'b0, 8'h40, 32'hf0f1f2f3, 32'h0},
    {OP_W, 1'b0, 8'h47, 32'h70717273, 32'h0},
    {OP_R, 1'b0, 8'h40, 32'h0, 32'hf0f1f2f3},
    {OP_R, 1'b0, 8'h47, 32'h0, 32'h70717273},
    {OP_R, 1'b0, 8'h20, 32'h0, 32'h00010203},
    {OP_R, 1'b0, 8'h21, 32'h0, 32'h04050607},
    {OP_W, 1'b0, 8'h60, 32'hdeadbeef, 32'h0},
    {OP_W, 1'b0, 8'h61, 32'h47114711, 32'h0},
    {OP_C, 1'b0, 8'h00, 32'h00003eef, 32'h47114711},
    {OP_R, 1'b0, 8'h60, 32'h0, 32'h0},
    {OP_R, 1'b0, 8'h61, 32'h0, 32'h0},
    {OP_R, 1'b0, 8'h7f, 32'h0, 32'h0},
    {OP_W, 1'b0, 8'h20, 32'hffffffff, 32'h0},
    {OP_R, 1'b0, 8'h20, 32'h0, 32'h00010203},
    {OP_F, 1'b0, 8'h00, 32'h0, 32'h1},
    {OP_R, 1'b0, 8'h20, 32'h0, 32'h0},
    {OP_R, 1'b0, 8'h21, 32'h0, 32'h0},
    {OP_W, 1'b0, 8'h40, 32'hfffefdfc, 32'h0},
    {OP_R, 1'b0, 8'h40, 32'h0, 32'hf0f1f2f3},
    {OP_W, 1'b0, 8'h60, 32'h12345678, 32'h0},
    {OP_W, 1'b0, 8'h61, 32'haaaaaaaa, 32'h0},
    {OP_C, 1'b0, 8'h00, 32'h00003eef, 32'h47114711},
    {OP_R, 1'b1, 8'h21, 32'h0, 32'h04050607},
    {OP_W, 1'b1, 8'h40, 32'hfffefdfc, 32'h0},
    {OP_R, 1'b1, 8'h40, 32'h0, 32'hfffefdfc},
    {OP_R, 1'b0, 8'h40, 32'h0, 32'hfffefdfc},
    {OP_W, 1'b1, 8'h60, 32'h0000cafe, 32'h0},
    {OP_W, 1'b1, 8'h61, 32'hf00ff00f, 32'h0},
    {OP_C, 1'b0, 8'h00, 32'h00004afe, 32'hf00ff00f},
    {OP_R, 1'b1, 8'h61, 32'h0, 32'h0}
  };

  localparam string TAG [NV] = '{
    "R5", "R5", "R5", "R5", "R4", "R4", "R7", "R7", "R7", "R8",
    "R8", "R10", "R11", "R11", "R2", "R4", "R4", "R6", "R6", "R9",
    "R9", "R9", "R4", "R5", "R5", "R6", "R7", "R7", "R7", "R8"
  };

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         busCs = 1'b0;
  logic         busWe = 1'b0;
  logic [7:0]   busAddr = '0;
  logic [31:0]  busWdata = '0;
  logic [31:0]  fetchAddr = '0;
  logic         fetchValid = 1'b0;
  logic         syscall = 1'b0;
  logic [31:0]  busRdata;
  logic         appMode;
  logic [63:0]  udiView;
  logic [255:0] cdiFlat;
  logic [14:0]  ramAddrScramble;
  logic [31:0]  ramDataScramble;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #10 clk = ~clk;

  secbank_top dut (
    .clk(clk), .rstN(rstN), .busCs(busCs), .busWe(busWe), .busAddr(busAddr),
    .busWdata(busWdata), .fetchAddr(fetchAddr), .fetchValid(fetchValid),
    .syscall(syscall), .busRdata(busRdata), .appMode(appMode), .udiView(udiView),
    .cdiFlat(cdiFlat), .ramAddrScramble(ramAddrScramble),
    .ramDataScramble(ramDataScramble)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    busCs = 1'b0;
    fetchValid = 1'b0;
    syscall = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic busWrite(input logic [7:0] a, input logic [31:0] d, input logic s);
    syscall = s;
    busCs = 1'b1; busWe = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busCs = 1'b0; busWe = 1'b0;
  endtask

  task automatic busRead(input logic [7:0] a, input logic s, output logic [31:0] d);
    syscall = s;
    busCs = 1'b1; busWe = 1'b0; busAddr = a;
    @(negedge clk);
    busCs = 1'b0;
    d = busRdata;
  endtask

  task automatic doFetch(input logic [31:0] a, input logic v);
    fetchAddr = a; fetchValid = v;
    @(negedge clk);
    fetchValid = 1'b0;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual 0x0 expected 0x1");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    doReset();
    @(negedge clk);
    // R1: reset state
    chk("R1", {63'h0, appMode}, 64'h0);
    chk("R1", {32'h0, busRdata}, 64'h0);
    chk("R1", {17'h0, ramAddrScramble, ramDataScramble}, 64'h0);
    chk("R1", {63'h0, cdiFlat != 256'h0}, 64'h0);
    chk("R4", udiView, 64'h04050607_00010203);

    // Table walk over the three privilege contexts
    for (int i = 0; i < NV; i++) begin
      logic [1:0]  op;
      logic        sc;
      logic [7:0]  ad;
      logic [31:0] dt;
      logic [31:0] ex;
      {op, sc, ad, dt, ex} = VEC[i];
      case (op)
        OP_W: busWrite(ad, dt, sc);
        OP_R: begin
          busRead(ad, sc, rd);
          chk(TAG[i], {32'h0, rd}, {32'h0, ex});
        end
        OP_F: begin
          doFetch(APP_START, 1'b1);
          chk(TAG[i], {63'h0, appMode}, {32'h0, ex});
        end
        default: chk(TAG[i], {17'h0, ramAddrScramble, ramDataScramble},
                     {dt, ex});
      endcase
    end
    syscall = 1'b0;
    @(negedge clk);

    // R3: syscall pulses do not leave application mode
    syscall = 1'b1;
    @(negedge clk);
    chk("R4", udiView, 64'h04050607_00010203);
    syscall = 1'b0;
    @(negedge clk);
    chk("R3", {63'h0, appMode}, 64'h1);
    chk("R4", udiView, 64'h0);

    // R1 again: reset out of application mode
    doReset();
    @(negedge clk);
    chk("R1", {63'h0, appMode}, 64'h0);
    chk("R1", {32'h0, cdiFlat[31:0]}, 64'h0);

    // R2: fetches that must not switch the mode
    doFetch(APP_START, 1'b0);
    chk("R2", {63'h0, appMode}, 64'h0);
    doFetch(APP_START + 32'd4, 1'b1);
    chk("R2", {63'h0, appMode}, 64'h0);

    // R10: read data arrives one cycle after the strobe and holds
    busCs = 1'b1; busWe = 1'b0; busAddr = 8'h21;
    #1;
    chk("R10", {32'h0, busRdata}, 64'h0);
    @(negedge clk);
    busCs = 1'b0;
    chk("R10", {32'h0, busRdata}, 64'h04050607);
    busAddr = 8'h20;
    @(negedge clk);
    chk("R10", {32'h0, busRdata}, 64'h04050607);

    done = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

endmodule